// File: doc/BRIEF.md
# Random Word Generator Register Front End

This block is the bus-facing side of a random number generator. A 32-bit register bus reaches five registers: a control word, a status word, a data port, an interrupt threshold and an interrupt mask. After software sets the enable bit, a one-bit entropy input is sampled at a selectable rate. The first samples are spent on a warm-up countdown that software loads through the status register. Once that count has run down, the samples are packed into 32-bit words and written into a small FIFO.

Software learns how many words are ready from the top byte of the status register. Each read of the data port takes one word out of the FIFO. An interrupt line rises when the number of stored words reaches a programmed level, unless the mask bit holds it low. The control register also keeps the settings for the oscillator masks and the jitter clock divider that the analogue entropy core would use. Those settings can be read back but have no effect inside this block. In test, a pseudo-random bit stream takes the place of that core.

Top module: `rng_regif`

## Requirements
- R1: After reset, the registers read back as follows: control (offset 0x00) reads 0, status (0x04) reads 0, threshold (0x0C) reads 0x10, mask (0x10) reads 1, and `irq` is low. Reading an offset that is not decoded returns 0.
- R2: Control keeps bits 27:16 (two 6-bit oscillator masks), 15:8 (divider count), 5 (divided clock source), 4 (jitter bypass), 1 (double speed) and 0 (enable). All other bits read 0. Writing 0xFFFFFFFC therefore reads back 0x0FFFFF30.
- R3: Status bits 31:24 give the number of stored words, bits 23:20 read 0 and bits 19:0 give the warm-up count.
- R4: A write to status loads bits 19:0 into the warm-up count. While that count is nonzero, each sampled bit decrements it by one and no word is produced.
- R5: With enable set and bit 1 clear, one entropy bit is sampled every second cycle. With bit 1 set, one is sampled every cycle. Each group of 32 samples makes one word, with the earliest sample in bit 31.
- R6: Each data-port (0x08) read of a non-empty FIFO returns the oldest word and removes it. A read of an empty FIFO returns 0 and the count stays 0.
- R7: The count never exceeds DEPTH (4 by default). A word completed while the FIFO is full, with no read in the same cycle, is dropped.
- R8: `irq` is high exactly when mask bit 0 is 0 and the stored word count is at least the threshold.
- R9: Clearing the enable bit stops sampling, keeps the stored words and discards a partly assembled word.
- R10: The threshold register keeps bits 4:0 and the mask register keeps bit 0. All other bits of both registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; at 0x08 it removes a word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| ent_bit | input | 1 | Entropy bit input |
| irq | output | 1 | Threshold interrupt, level |

## Verification
The checker verifies every cycle that the count stays within its bound, and that no word is produced during warm-up or while the generator is disabled. It also checks that the warm-up count steps down by exactly one per sample, that a read without a simultaneous fill lowers the count by one, that an empty data read returns 0, and that a set mask keeps the interrupt low. Only the bench scenarios can show the things that depend on history: the bit rate in each speed mode, the packing and order of words, the dropping of words when the FIFO is full, the words surviving a disable, and the register readback masks. The bench follows all of these with its queue model and compares the status word and the interrupt on every clock.

// File: rtl/rng_regif_pkg.sv
package rng_regif_pkg;
  localparam int ADDR_W = 5;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_DATA = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_THR  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_IMSK = 5'h10;
  // writable control fields: osc masks, divider, src, bypass, speed, enable
  localparam logic [31:0] CTRL_KEEP = 32'h0FFF_FF33;

  // interrupt level from fill, threshold and the off bit
  function automatic logic irq_level(input logic [7:0] fill,
                                     input logic [7:0] thr,
                                     input logic       off);
    return !off && (fill >= thr);
  endfunction

  // status word: fill byte on top, warm-up count below
  function automatic logic [31:0] status_word(input logic [7:0]  fill,
                                              input logic [23:0] warm);
    return {fill, warm};
  endfunction

  // circular pointer advance for a buffer of arbitrary depth
  function automatic int unsigned ptr_next(input int unsigned p,
                                           input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/rng_bitgen.sv
module rng_bitgen #(
  parameter int WARM_W = 20,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              dbl,
  input  logic              ent,
  input  logic              warm_ld,
  input  logic [WARM_W-1:0] warm_val,
  output logic              tick,
  output logic              push,
  output logic [WORD_W-1:0] word,
  output logic [WARM_W-1:0] warm
);
  localparam int BC_W = $clog2(WORD_W);

  logic              phase;
  logic [WORD_W-1:0] sh;
  logic [BC_W-1:0]   bc;
  logic              gen;

  assign tick = en && (dbl || phase);
  assign gen  = tick && !warm_ld && (warm == '0);
  assign word = {sh[WORD_W-2:0], ent};
  assign push = gen && (bc == BC_W'(WORD_W - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= 1'b0;
      sh    <= '0;
      bc    <= '0;
      warm  <= '0;
    end else begin
      phase <= en ? ~phase : 1'b0;
      if (warm_ld) begin
        warm <= warm_val;
        bc   <= '0;
      end else if (!en) begin
        bc <= '0;
      end else if (tick) begin
        if (warm != '0) begin
          warm <= warm - 1'b1;
        end else begin
          sh <= word;
          bc <= push ? '0 : bc + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rng_wordfifo.sv
module rng_wordfifo #(
  parameter int DEPTH = 4,
  parameter int W     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] cnt
);
  import rng_regif_pkg::*;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rp, wp;
  logic          accept;

  assign accept = push && ((cnt != CW'(DEPTH)) || pop);
  assign dout   = mem[rp];

  always_ff @(posedge clk) begin
    if (accept) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (pop)    rp <= PW'(ptr_next(int'(rp), DEPTH));
      if (accept) wp <= PW'(ptr_next(int'(wp), DEPTH));
      case ({accept, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/rng_regif.sv
module rng_regif #(
  parameter int DEPTH   = 4,
  parameter int WARM_W  = 20,
  parameter int THR_W   = 5,
  parameter int THR_RST = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        ent_bit,
  output logic        irq
);
  import rng_regif_pkg::*;
  localparam int CW = $clog2(DEPTH + 1);

  logic [31:0]       ctrl_q;
  logic [THR_W-1:0]  thr_q;
  logic              imsk_q;

  // named internal events
  logic              warm_ld;
  logic              gen_tick;
  logic              gen_push;
  logic [31:0]       gen_word;
  logic [WARM_W-1:0] warm_cnt;
  logic              data_pop;
  logic [CW-1:0]     fifo_cnt;
  logic [31:0]       fifo_head;
  logic [7:0]        fill8;

  assign warm_ld  = bus_wr && (bus_addr == OFS_STAT);
  assign data_pop = bus_rd && (bus_addr == OFS_DATA) && (fifo_cnt != '0);
  assign fill8    = 8'(fifo_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      thr_q  <= THR_W'(THR_RST);
      imsk_q <= 1'b1;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_CTRL: ctrl_q <= bus_wdata & CTRL_KEEP;
        OFS_THR:  thr_q  <= bus_wdata[THR_W-1:0];
        OFS_IMSK: imsk_q <= bus_wdata[0];
        default:  ;
      endcase
    end
  end

  rng_bitgen #(.WARM_W(WARM_W), .WORD_W(32)) u_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ctrl_q[0]),
    .dbl      (ctrl_q[1]),
    .ent      (ent_bit),
    .warm_ld  (warm_ld),
    .warm_val (bus_wdata[WARM_W-1:0]),
    .tick     (gen_tick),
    .push     (gen_push),
    .word     (gen_word),
    .warm     (warm_cnt)
  );

  rng_wordfifo #(.DEPTH(DEPTH), .W(32)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (gen_push),
    .pop   (data_pop),
    .din   (gen_word),
    .dout  (fifo_head),
    .cnt   (fifo_cnt)
  );

  always_comb begin
    case (bus_addr)
      OFS_CTRL: bus_rdata = ctrl_q;
      OFS_STAT: bus_rdata = status_word(fill8, 24'(warm_cnt));
      OFS_DATA: bus_rdata = (fifo_cnt != '0) ? fifo_head : 32'h0;
      OFS_THR:  bus_rdata = 32'(thr_q);
      OFS_IMSK: bus_rdata = {31'h0, imsk_q};
      default:  bus_rdata = 32'h0;
    endcase
  end

  assign irq = irq_level(fill8, 8'(thr_q), imsk_q);
endmodule

// File: rtl/rng_regif_chk.sv
module rng_regif_chk #(
  parameter int DEPTH  = 4,
  parameter int WARM_W = 20
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       en,
  input logic                       imsk,
  input logic                       tick,
  input logic                       warm_ld,
  input logic                       push,
  input logic                       pop,
  input logic [WARM_W-1:0]          warm,
  input logic [$clog2(DEPTH+1)-1:0] cnt,
  input logic                       bus_rd,
  input logic [4:0]                 bus_addr,
  input logic [31:0]                bus_rdata,
  input logic                       irq
);
  localparam int CW = $clog2(DEPTH + 1);

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  p_warm_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != '0) |-> !push);

  p_warm_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !warm_ld && warm != '0) |=> (warm == $past(warm) - WARM_W'(1)));

  p_idle_no_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !push);

  p_pop_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (cnt == $past(cnt) - CW'(1)));

  p_empty_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 5'h08 && cnt == '0) |-> (bus_rdata == 32'h0));

  p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    imsk |-> !irq);
endmodule

bind rng_regif rng_regif_chk #(.DEPTH(DEPTH), .WARM_W(WARM_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (ctrl_q[0]),
  .imsk      (imsk_q),
  .tick      (gen_tick),
  .warm_ld   (warm_ld),
  .push      (gen_push),
  .pop       (data_pop),
  .warm      (warm_cnt),
  .cnt       (fifo_cnt),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq       (irq)
);

// File: tb/rng_regif_test.sv
module rng_regif_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = 5'h04;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        ent_bit = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;

  rng_regif uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ent_bit(ent_bit), .irq(irq)
  );

  always #2 clk = ~clk;

  // stand-in entropy: 16-bit LFSR
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ent_bit <= lfsr[0];
  end

  // behavioural reference model
  int unsigned m_ctrl, m_thr, m_mask, m_warm, m_bc;
  bit          m_phase, m_tick, m_en;
  logic [31:0] m_sh;
  logic [31:0] q[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_thr = 16; m_mask = 1; m_warm = 0; m_bc = 0;
      m_phase = 0; m_sh = 0; q.delete();
    end else begin
      m_en   = m_ctrl[0];
      m_tick = m_en && (m_ctrl[1] || m_phase);
      if (bus_rd && bus_addr == 5'h08 && q.size() > 0) void'(q.pop_front());
      if (bus_wr && bus_addr == 5'h04) begin
        m_warm = bus_wdata & 32'hFFFFF;
        m_bc = 0;
      end else if (!m_en) begin
        m_bc = 0;
      end else if (m_tick) begin
        if (m_warm != 0) m_warm = m_warm - 1;
        else begin
          m_sh = {m_sh[30:0], ent_bit};
          m_bc = m_bc + 1;
          if (m_bc == 32) begin
            m_bc = 0;
            if (q.size() < 4) q.push_back(m_sh);
          end
        end
      end
      m_phase = m_en ? !m_phase : 1'b0;
      if (bus_wr) begin
        case (bus_addr)
          5'h00: m_ctrl = bus_wdata & 32'h0FFFFF33;
          5'h0C: m_thr  = bus_wdata & 32'h1F;
          5'h10: m_mask = bus_wdata & 32'h1;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [31:0] m_status();
    return {8'(q.size()), 4'h0, 20'(m_warm)};
  endfunction

  function automatic logic m_irq();
    return (m_mask == 0) && (q.size() >= m_thr);
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // per-clock comparison of the status word and the interrupt
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (bus_addr == 5'h04)
        check(bus_rdata === m_status(), "R3/R4 status", bus_rdata, m_status());
      check(irq === m_irq(), "R8 irq", 32'(irq), 32'(m_irq()));
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 5'h04;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = 5'h04;
  endtask

  task automatic rd_expect(input logic [4:0] a, input logic [31:0] exp,
                           input string req);
    logic [31:0] d;
    rd(a, d);
    check(d === exp, req, d, exp);
  endtask

  task automatic pop_expect(input string req);
    logic [31:0] d;
    logic [31:0] exp;
    @(negedge clk);
    bus_addr = 5'h08; bus_rd = 1'b1;
    #1 d = bus_rdata;
    exp = (q.size() > 0) ? q[0] : 32'h0;
    check(d === exp, req, d, exp);
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = 5'h04;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rd_expect(5'h00, 32'h0, "R1 ctrl reset");
    rd_expect(5'h04, 32'h0, "R1 status reset");
    rd_expect(5'h0C, 32'h10, "R1 thr reset");
    rd_expect(5'h10, 32'h1, "R1 mask reset");
    rd_expect(5'h14, 32'h0, "R1 undecoded offset");
    check(irq === 1'b0, "R1 irq reset", 32'(irq), 32'h0);
    pop_expect("R6 empty read zero");
    rd_expect(5'h04, 32'h0, "R6 count stays 0");
    // R2 / R10 readback masks
    wr(5'h00, 32'hFFFF_FFFC);
    rd_expect(5'h00, 32'h0FFF_FF30, "R2 ctrl mask");
    wr(5'h00, 32'h0);
    wr(5'h0C, 32'hFFFF_FFFF);
    rd_expect(5'h0C, 32'h1F, "R10 thr mask");
    wr(5'h10, 32'hFFFF_FFFE);
    rd_expect(5'h10, 32'h0, "R10 mask bit0");
    wr(5'h10, 32'h1);
    // R4 warm-up load
    wr(5'h04, 32'hFFFF_FFFF);
    rd_expect(5'h04, 32'h000F_FFFF, "R3 R4 warm load");
    wr(5'h04, 32'd40);
    wr(5'h00, 32'h1);
    repeat (60) @(negedge clk);
    rd_expect(5'h04, m_status(), "R4 warm countdown");
    check(q.size() == 0, "R4 no words in warm-up", 32'(q.size()), 32'h0);
    // fill until full, then hold (R7)
    repeat (600) @(negedge clk);
    rd_expect(5'h04, 32'h0400_0000, "R7 saturate at depth");
    // R9 disable keeps words
    wr(5'h00, 32'h0);
    repeat (100) @(negedge clk);
    rd_expect(5'h04, 32'h0400_0000, "R9 words kept");
    // R8 threshold interrupt
    wr(5'h0C, 32'd2);
    wr(5'h10, 32'h0);
    #1 check(irq === 1'b1, "R8 irq at threshold", 32'(irq), 32'h1);
    for (int i = 0; i < 3; i++) pop_expect("R6 fifo order");
    #1 check(irq === 1'b0, "R8 irq below threshold", 32'(irq), 32'h0);
    pop_expect("R6 last word");
    pop_expect("R6 empty after drain");
    rd_expect(5'h04, 32'h0, "R6 count zero");
    // R5 double speed: one word after 32 cycles
    wr(5'h10, 32'h1);
    wr(5'h00, 32'h3);
    repeat (40) @(negedge clk);
    rd_expect(5'h04, 32'h0100_0000, "R5 double speed word");
    wr(5'h00, 32'h0);
    pop_expect("R5 packed word");
    // R5 normal speed: none after 40 cycles
    wr(5'h00, 32'h1);
    repeat (40) @(negedge clk);
    rd_expect(5'h04, 32'h0, "R5 normal speed slower");
    repeat (40) @(negedge clk);
    rd_expect(5'h04, 32'h0100_0000, "R5 normal speed word");
    wr(5'h00, 32'h0);
    pop_expect("R5 normal packed word");
    finish_run();
  end
endmodule